// File: doc/BRIEF.md
# Floppy Controller Host Register Front End

This block is the byte-wide, port-mapped register front end of a two-drive, single-density floppy disk controller. It claims a window of eight consecutive byte ports that starts at a parameterised base address. A host reads three of these ports: a subsystem status byte, a two-bit result type and a result byte. The host writes three others to load a 16-bit parameter-block address, to start an operation, or to soft-reset the subsystem. Reads of the other ports return zero, and writes to them have no effect.

No separate command or acknowledge register exists. When the host writes the high address byte, the block emits a one-cycle start pulse to the command sequencer, and the pulse carries the full latched block address. When the sequencer finishes, it returns a done strobe with a result type, an error byte and the interrupt-disable setting of the command. The block then sets its interrupt flip-flop. When the host reads the result type, the flip-flop is cleared.

The block tracks the ready state of each drive from its drive-present input. It also keeps a ready-changed flag, so that a result of the ready-status kind reports the current drive readiness in place of the error byte.

Top module: `flop_host_if`

## Requirements
- R1: The status port (offset 0) reads as follows: bit 0 is drive 0 ready, bit 1 is drive 1 ready, bit 2 is the interrupt flip-flop, bit 3 is always 1, and bits 7..4 are 0. Each ready bit follows its drive-present input one clock later.
- R2: A write to offset 1 latches the low address byte. A write to offset 2 while `seq_busy` is low latches the high byte. In the cycle after that write, `start_pulse` is high for exactly one cycle, and `start_addr` = {high, low} then holds.
- R3: A write to offset 2 while `seq_busy` is high is ignored. No pulse is produced and the high byte is not loaded.
- R4: In the cycle after a `done_stb`, the interrupt flip-flop is 1, the result type equals `done_rtype` and the stored error byte equals `done_rbyte`.
- R5: A read of offset 1 returns {6'b0, result type}, where 00 is complete with error byte, 01 is complete linked, 10 is drive-ready status and 11 is reserved. From the next cycle on, the interrupt flip-flop is 0 and the result type is 00. If `done_stb` arrives in the same cycle, the done strobe takes priority.
- R6: A read of offset 3 returns the stored error byte unless R7 applies. The error byte bits are: bit 7 not ready, bit 6 write error, bit 5 write protect, bit 4 overrun/underrun, bit 3 address, bit 2 seek, bit 1 CRC, bit 0 deleted record.
- R7: The ready-changed flag is set when any drive-present input differs from its ready bit. While the result type is 10 and this flag is set, offset 3 returns drive 1 ready in bit 7, drive 0 ready in bit 6 and 0 in bits 5..0.
- R8: A write of any value to offset 7 soft-resets the subsystem. In the next cycle the result type is 00, the error byte is 0, the interrupt flip-flop is 0, the ready-changed flag is 0 and the ready bits equal the drive-present inputs. A soft reset takes priority over a same-cycle `done_stb`.
- R9: `irq` is high only while the interrupt flip-flop is set and the `done_irq_off` value latched with the last done strobe was 0.
- R10: `io_rdata` is 0x00 for offsets 2, 4, 5 and 6, for addresses outside the window, and whenever `io_rd` is low. Writes to offsets 0, 3, 4, 5 and 6, and writes outside the window, change no state.
- R11: After the synchronous reset, status reads as 0x08 plus the ready bits, the result type and error byte are 0, and `irq` and `start_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Host port address |
| io_rd | input | 1 | Host read strobe (side effects take place at the clock edge) |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data (combinational, zero unless a defined port is read) |
| drv_present | input | 2 | Per-drive present/ready input |
| seq_busy | input | 1 | Sequencer busy; blocks new starts |
| start_pulse | output | 1 | One-cycle operation start |
| start_addr | output | 16 | Latched parameter-block address |
| done_stb | input | 1 | Sequencer completion strobe |
| done_rtype | input | 2 | Result type reported with the done strobe |
| done_rbyte | input | 8 | Error byte reported with the done strobe |
| done_irq_off | input | 1 | The command disabled the completion interrupt |
| irq | output | 1 | Interrupt request |

## Verification
A table of completion reports is applied in turn. It covers an error-type result, a linked result, a result with its interrupt disabled, the reserved type, and a ready-status result with no ready change. Together these separate a correct type/byte return and interrupt gating from a design that ignores the disable bit or always substitutes readiness. Directed cases follow. They toggle a drive-present input and then report a ready-status result, which separates the readiness byte from the error byte. They also give the done strobe the same cycle as a type read, and the same cycle as a soft reset, which exposes the wrong priority. Finally, they start an operation with the sequencer idle and again with it busy, and they access every undefined offset, so that extra decodes and stray side effects are caught.

// File: rtl/fhi_pkg.sv
package fhi_pkg;

    localparam int NUM_DRIVES = 2;

    // Port offsets inside the eight-byte window
    localparam logic [2:0] OFS_STATUS = 3'd0;
    localparam logic [2:0] OFS_TYPE   = 3'd1;
    localparam logic [2:0] OFS_ADDRHI = 3'd2;
    localparam logic [2:0] OFS_RBYTE  = 3'd3;
    localparam logic [2:0] OFS_SRST   = 3'd7;

    typedef enum logic [1:0] {
        RT_ERROR  = 2'b00,
        RT_LINKED = 2'b01,
        RT_READY  = 2'b10,
        RT_RSVD   = 2'b11
    } rtype_e;

    typedef struct packed {
        logic rd_status;
        logic rd_type;
        logic rd_rbyte;
        logic wr_lo;
        logic wr_hi;
        logic wr_srst;
    } port_hit_t;

    // Result-byte layout for a ready-status report
    function automatic logic [7:0] ready_byte(input logic [NUM_DRIVES-1:0] rdy);
        logic [7:0] b;
        b = 8'h00;
        for (int i = 0; i < NUM_DRIVES; i++) b[6+i] = rdy[i];
        return b;
    endfunction

endpackage

// File: rtl/fhi_decode.sv
module fhi_decode
    import fhi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h88
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output port_hit_t         hit
);
    logic       in_win;
    logic [2:0] ofs;

    assign in_win = (io_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
    assign ofs    = io_addr[2:0];

    always_comb begin
        hit           = '0;
        hit.rd_status = in_win && io_rd && (ofs == OFS_STATUS);
        hit.rd_type   = in_win && io_rd && (ofs == OFS_TYPE);
        hit.rd_rbyte  = in_win && io_rd && (ofs == OFS_RBYTE);
        hit.wr_lo     = in_win && io_wr && (ofs == OFS_TYPE);
        hit.wr_hi     = in_win && io_wr && (ofs == OFS_ADDRHI);
        hit.wr_srst   = in_win && io_wr && (ofs == OFS_SRST);
    end
endmodule

// File: rtl/fhi_ready.sv
module fhi_ready
    import fhi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  srst,
    input  logic [NUM_DRIVES-1:0] drv_present,
    output logic [NUM_DRIVES-1:0] rdy,
    output logic                  rdy_chg
);
    logic [NUM_DRIVES-1:0] diff;

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        always_ff @(posedge clk) begin
            rdy[g] <= drv_present[g];
        end
        assign diff[g] = rdy[g] ^ drv_present[g];
    end

    always_ff @(posedge clk) begin
        if (rst || srst)  rdy_chg <= 1'b0;
        else if (|diff)   rdy_chg <= 1'b1;
    end

    // R7: a drive change outside soft reset raises the flag
    a_r7_change_flags: assert property (@(posedge clk) disable iff (rst)
        ((rdy != drv_present) && !srst) |=> rdy_chg);
    // R8: soft reset drops the flag and re-derives readiness
    a_r8_srst_ready: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!rdy_chg && rdy == $past(drv_present)));
endmodule

// File: rtl/fhi_result.sv
module fhi_result
    import fhi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       srst,
    input  logic       rd_type,
    input  logic       done_stb,
    input  logic [1:0] done_rtype,
    input  logic [7:0] done_rbyte,
    input  logic       done_irq_off,
    output logic       intff,
    output rtype_e     rtype,
    output logic [7:0] err_byte,
    output logic       irq
);
    logic irq_en;

    // Priority: reset, soft reset, done report, type read
    always_ff @(posedge clk) begin
        if (rst || srst) begin
            intff    <= 1'b0;
            rtype    <= RT_ERROR;
            err_byte <= 8'h00;
            irq_en   <= 1'b0;
        end else if (done_stb) begin
            intff    <= 1'b1;
            rtype    <= rtype_e'(done_rtype);
            err_byte <= done_rbyte;
            irq_en   <= !done_irq_off;
        end else if (rd_type) begin
            intff    <= 1'b0;
            rtype    <= RT_ERROR;
        end
    end

    assign irq = intff && irq_en;

    a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
        (done_stb && !srst) |=> (intff && rtype == $past(done_rtype)
                                 && err_byte == $past(done_rbyte)));
    a_r5_type_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_type && !done_stb && !srst) |=> (!intff && rtype == RT_ERROR));
    a_r8_srst_clears: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!intff && rtype == RT_ERROR && err_byte == 8'h00));
    a_r9_irq_needs_ff: assert property (@(posedge clk) disable iff (rst)
        irq |-> intff);
endmodule

// File: rtl/flop_host_if.sv
module flop_host_if
    import fhi_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h88
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [1:0]  drv_present,
    input  logic        seq_busy,
    output logic        start_pulse,
    output logic [15:0] start_addr,
    input  logic        done_stb,
    input  logic [1:0]  done_rtype,
    input  logic [7:0]  done_rbyte,
    input  logic        done_irq_off,
    output logic        irq
);
    port_hit_t             hit;
    logic [NUM_DRIVES-1:0] rdy;
    logic                  rdy_chg;
    logic                  intff;
    rtype_e                rtype;
    logic [7:0]            err_byte;
    logic [7:0]            addr_lo, addr_hi;
    logic [7:0]            status;

    fhi_decode #(.ADDR_W(8), .BASE_ADDR(BASE_ADDR)) u_dec (
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .hit(hit)
    );

    fhi_ready u_rdy (
        .clk(clk), .rst(rst), .srst(hit.wr_srst),
        .drv_present(drv_present), .rdy(rdy), .rdy_chg(rdy_chg)
    );

    fhi_result u_res (
        .clk(clk), .rst(rst), .srst(hit.wr_srst), .rd_type(hit.rd_type),
        .done_stb(done_stb), .done_rtype(done_rtype), .done_rbyte(done_rbyte),
        .done_irq_off(done_irq_off), .intff(intff), .rtype(rtype),
        .err_byte(err_byte), .irq(irq)
    );

    // Parameter-block address latch and start generation
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo     <= 8'h00;
            addr_hi     <= 8'h00;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (hit.wr_lo) addr_lo <= io_wdata;
            if (hit.wr_hi && !seq_busy) begin
                addr_hi     <= io_wdata;
                start_pulse <= 1'b1;
            end
        end
    end

    assign start_addr = {addr_hi, addr_lo};

    always_comb begin
        status = 8'h08;
        status[2] = intff;
        for (int i = 0; i < NUM_DRIVES; i++) status[i] = rdy[i];
    end

    always_comb begin
        io_rdata = 8'h00;
        if (hit.rd_status)
            io_rdata = status;
        else if (hit.rd_type)
            io_rdata = {6'b0, rtype};
        else if (hit.rd_rbyte)
            io_rdata = (rtype == RT_READY && rdy_chg) ? ready_byte(rdy) : err_byte;
    end

    a_r2_start_cause: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(io_wr && io_addr == BASE_ADDR + 8'd2 && !seq_busy));
    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);
    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == BASE_ADDR + 8'd2 && seq_busy) |=>
            (!start_pulse && $stable(start_addr)));
    a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'h00);
endmodule

// File: tb/flop_host_if_bench.sv
`timescale 1ns/1ps
module flop_host_if_bench;
    localparam logic [7:0] B = 8'h88;

    logic        clk = 1'b0, rst = 1'b1;
    logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00, io_rdata;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [1:0]  drv_present = 2'b01;
    logic        seq_busy = 1'b0, start_pulse, irq;
    logic [15:0] start_addr;
    logic        done_stb = 1'b0, done_irq_off = 1'b0;
    logic [1:0]  done_rtype = 2'b00;
    logic [7:0]  done_rbyte = 8'h00;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    flop_host_if u_flop_host_if (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .drv_present(drv_present),
        .seq_busy(seq_busy), .start_pulse(start_pulse), .start_addr(start_addr),
        .done_stb(done_stb), .done_rtype(done_rtype), .done_rbyte(done_rbyte),
        .done_irq_off(done_irq_off), .irq(irq)
    );

    always #2 clk = ~clk;

    // Completion reports: {rtype, rbyte, irq_off}
    localparam int NV = 5;
    localparam logic [10:0] VEC [NV] = '{
        {2'b00, 8'h80, 1'b0},
        {2'b01, 8'hA1, 1'b0},
        {2'b00, 8'h08, 1'b1},
        {2'b11, 8'h42, 1'b0},
        {2'b10, 8'h24, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic report(input logic [1:0] t, input logic [7:0] b, input logic off);
        @(negedge clk);
        done_stb = 1'b1; done_rtype = t; done_rbyte = b; done_irq_off = off;
        @(negedge clk);
        done_stb = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state, R1 status layout
        rd(B, d);       check("R11 status after reset", {8'h0, d}, 16'h0009);
        rd(B+3, d);     check("R11 error byte after reset", {8'h0, d}, 16'h0000);
        check("R11 irq low", {15'h0, irq}, 16'h0);
        check("R11 no start", {15'h0, start_pulse}, 16'h0);
        rd(B+1, d);     check("R11 type after reset", {8'h0, d}, 16'h0000);

        // R4 R5 R6 R9 table of completion reports
        for (int i = 0; i < NV; i++) begin
            report(VEC[i][10:9], VEC[i][8:1], VEC[i][0]);
            rd(B, d);   check("R4 status intff bit", {8'h0, d}, 16'h000D);
            check("R9 irq gating", {15'h0, irq}, {15'h0, !VEC[i][0]});
            rd(B+3, d); check("R6 error byte", {8'h0, d}, {8'h0, VEC[i][8:1]});
            rd(B+1, d); check("R5 type read", {8'h0, d}, {14'h0, VEC[i][10:9]});
            rd(B, d);   check("R5 intff cleared", {8'h0, d}, 16'h0009);
            check("R9 irq dropped", {15'h0, irq}, 16'h0);
            rd(B+1, d); check("R5 type forced 00", {8'h0, d}, 16'h0000);
        end

        // R2 start with idle sequencer
        wr(B+1, 8'h34);
        wr(B+2, 8'h12);
        check("R2 start pulse", {15'h0, start_pulse}, 16'h1);
        check("R2 start addr", start_addr, 16'h1234);
        @(negedge clk);
        check("R2 pulse one cycle", {15'h0, start_pulse}, 16'h0);

        // R3 start while busy
        seq_busy = 1'b1;
        wr(B+2, 8'h99);
        check("R3 no pulse when busy", {15'h0, start_pulse}, 16'h0);
        check("R3 addr held when busy", start_addr, 16'h1234);
        seq_busy = 1'b0;

        // R1 R7 ready change and ready-status result
        drv_present = 2'b11;
        @(negedge clk);
        rd(B, d);       check("R1 ready follows input", {8'h0, d}, 16'h000B);
        report(2'b10, 8'h5A, 1'b0);
        rd(B+3, d);     check("R7 ready byte", {8'h0, d}, 16'h00C0);
        rd(B+1, d);

        // R8 soft reset, then ready-type without change flag
        report(2'b00, 8'hFF, 1'b0);
        wr(B+7, 8'h00);
        rd(B, d);       check("R8 status after soft reset", {8'h0, d}, 16'h000B);
        rd(B+3, d);     check("R8 error byte cleared", {8'h0, d}, 16'h0000);
        report(2'b10, 8'h5A, 1'b0);
        rd(B+3, d);     check("R7 flag cleared gives error byte", {8'h0, d}, 16'h005A);
        rd(B+1, d);

        // R5 done wins over same-cycle type read
        @(negedge clk);
        io_addr = B+1; io_rd = 1'b1; done_stb = 1'b1; done_rtype = 2'b01; done_rbyte = 8'h11;
        @(negedge clk);
        io_rd = 1'b0; done_stb = 1'b0;
        rd(B, d);       check("R5 done priority intff", {8'h0, d}, 16'h000F);
        rd(B+1, d);     check("R5 done priority type", {8'h0, d}, 16'h0001);

        // R8 soft reset wins over same-cycle done
        @(negedge clk);
        io_addr = B+7; io_wr = 1'b1; done_stb = 1'b1; done_rtype = 2'b01; done_rbyte = 8'h77;
        @(negedge clk);
        io_wr = 1'b0; done_stb = 1'b0;
        rd(B, d);       check("R8 srst priority status", {8'h0, d}, 16'h000B);
        rd(B+3, d);     check("R8 srst priority byte", {8'h0, d}, 16'h0000);

        // R10 undefined ports and outside window
        report(2'b00, 8'h44, 1'b0);
        wr(B+0, 8'hFF); wr(B+3, 8'hFF); wr(B+4, 8'hFF); wr(B+5, 8'hFF); wr(B+6, 8'hFF);
        wr(8'h0A, 8'hFF);
        rd(B+3, d);     check("R10 writes ignored byte", {8'h0, d}, 16'h0044);
        rd(B, d);       check("R10 writes ignored status", {8'h0, d}, 16'h000F);
        check("R10 no stray start", start_addr, 16'h1234);
        rd(B+2, d);     check("R10 read offset 2", {8'h0, d}, 16'h0000);
        rd(B+4, d);     check("R10 read offset 4", {8'h0, d}, 16'h0000);
        rd(B+6, d);     check("R10 read offset 6", {8'h0, d}, 16'h0000);
        rd(8'h08, d);   check("R10 read outside window", {8'h0, d}, 16'h0000);
        rd(8'h09, d);
        rd(B, d);       check("R10 outside read keeps intff", {8'h0, d}, 16'h000F);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule